// File: doc/BRIEF.md
# Digit Brightness and Flash Gate

This block decides, clock by clock, which digits of an eight-digit multiplexed dot-matrix LED display may have their column drivers on. It forms one enable per digit. Outside the block, each enable is ANDed with that digit's column drive. The enable combines two things. The first is a brightness duty pattern, which lowers the average LED current while the peak drive stays the same. The second is a slow visibility phase, used for per-digit flashing and for blinking the whole display.

Five control bits set the behaviour. A 3-bit brightness code selects one of eight duty levels, from full on to blank. A flash-enable bit makes the digits marked in an 8-bit flash mask follow the slow phase. A blink-enable bit makes every digit follow the slow phase and takes priority over flashing. The slow phase is also an output, so neighbouring logic can use it. Several displays that share a clock and a reset keep their duty frames and flash phases in step, because reset clears both timebases.

Top module: `digit_gate_mod`

## Requirements
- R1: While reset is held, and before the first clock edge after its release, the duty slot index is 0 and the slow phase is high. With the brightness code set to 0, every digit enable is then 1.
- R2: The duty frame lasts 15 clocks. Over any aligned frame, a digit that is not flash-gated is enabled for 15, 12, 8, 6, 4, 3, 2 or 0 clocks, for brightness codes 0 to 7 (ctrl[2:0]).
- R3: Brightness code 7 holds every digit enable at 0, whatever the other inputs are.
- R4: Brightness code 0, with flash and blink both off, holds every digit enable at 1.
- R5: The slow phase output is high for 14336 clocks and then low for 14336 clocks, repeating with a period of 28672 clocks counted from reset release.
- R6: With ctrl[3] = 1 and ctrl[4] = 0, a digit i whose flash_mask bit i is 1 is enabled only when the slow phase is high and its duty slot is on. Digits whose mask bit is 0 follow the duty pattern alone.
- R7: With ctrl[3] = 0 and ctrl[4] = 0, the flash mask has no effect. All eight enables are equal and follow the duty pattern.
- R8: With ctrl[4] = 1, all eight digits are gated by the slow phase, whatever ctrl[3] and the flash mask hold.
- R9: The enabled duty slots are the first N of the frame. After k clocks since reset release, the duty slot is on exactly when (k mod 15) < N, where N is the count given in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous active-low reset of both timebases |
| ctrl_i | input | 5 | [2:0] brightness code, [3] flash enable, [4] blink enable |
| flash_mask_i | input | 8 | Per-digit flash select, bit i for digit i |
| digit_en_o | output | 8 | Per-digit column enable |
| slow_phase_o | output | 1 | Flash/blink visibility phase, 1 = visible |

## Verification
The assertions assume that the control word and the flash mask are steady levels from the host register. They may change at any clock, and they must not carry X or Z. The phase-timing assertion also assumes that reset is the only thing that restarts the timebase, so that every phase change is preceded by a full half-period. The stimulus keeps to these assumptions. It changes the inputs only at falling edges and always with defined values. It asserts reset only through a task that holds it across a clock edge, and it runs long enough to cover more than two full slow periods with random controls. Directed sequences step through each brightness code from the start of an aligned frame.

// File: rtl/lgm_pkg.sv
package lgm_pkg;

    localparam int FRAME_SLOTS = 15;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS);

    typedef logic [2:0] bright_t;

    typedef enum logic {
        PH_SHOW = 1'b0,
        PH_HIDE = 1'b1
    } phase_e;

    // Number of lit slots in a 15-slot frame for each brightness code.
    function automatic logic [SLOT_W-1:0] lit_slots(input bright_t code);
        logic [SLOT_W-1:0] n;
        unique case (code)
            3'd0: n = SLOT_W'(15);
            3'd1: n = SLOT_W'(12);
            3'd2: n = SLOT_W'(8);
            3'd3: n = SLOT_W'(6);
            3'd4: n = SLOT_W'(4);
            3'd5: n = SLOT_W'(3);
            3'd6: n = SLOT_W'(2);
            default: n = SLOT_W'(0);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lgm_duty.sv
module lgm_duty
    import lgm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  bright_t code_i,
    output logic    on_o
);
    logic [SLOT_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            slot_q <= '0;
        else if (slot_q == SLOT_W'(FRAME_SLOTS - 1))
            slot_q <= '0;
        else
            slot_q <= slot_q + 1'b1;
    end

    always_comb begin
        on_o = (slot_q < lit_slots(code_i));
    end

endmodule

// File: rtl/lgm_phase.sv
module lgm_phase
    import lgm_pkg::*;
#(
    parameter int PERIOD = 28672
) (
    input  logic clk,
    input  logic rst_n,
    output logic show_o
);
    localparam int HALF = PERIOD / 2;
    localparam int CW   = $clog2(HALF);

    phase_e        state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          last_tick;

    assign last_tick = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_SHOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = last_tick ? '0 : cnt_q + 1'b1;
        unique case (state_q)
            PH_SHOW: if (last_tick) state_d = PH_HIDE;
            PH_HIDE: if (last_tick) state_d = PH_SHOW;
        endcase
    end

    always_comb begin
        unique case (state_q)
            PH_SHOW: show_o = 1'b1;
            PH_HIDE: show_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/lgm_gate.sv
module lgm_gate #(
    parameter int DIGITS = 8
) (
    input  logic              duty_on_i,
    input  logic              show_i,
    input  logic              flash_en_i,
    input  logic              blink_en_i,
    input  logic [DIGITS-1:0] mask_i,
    output logic [DIGITS-1:0] en_o
);
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic follows_phase;
        assign follows_phase = blink_en_i | (flash_en_i & mask_i[g]);
        assign en_o[g] = duty_on_i & (show_i | ~follows_phase);
    end

endmodule

// File: rtl/digit_gate_mod.sv
module digit_gate_mod
    import lgm_pkg::*;
#(
    parameter int DIGITS = 8,
    parameter int PERIOD = 28672
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        ctrl_i,
    input  logic [DIGITS-1:0] flash_mask_i,
    output logic [DIGITS-1:0] digit_en_o,
    output logic              slow_phase_o
);
    logic duty_on;

    lgm_duty u_duty (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_i (ctrl_i[2:0]),
        .on_o   (duty_on)
    );

    lgm_phase #(.PERIOD(PERIOD)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .show_o (slow_phase_o)
    );

    lgm_gate #(.DIGITS(DIGITS)) u_gate (
        .duty_on_i  (duty_on),
        .show_i     (slow_phase_o),
        .flash_en_i (ctrl_i[3]),
        .blink_en_i (ctrl_i[4]),
        .mask_i     (flash_mask_i),
        .en_o       (digit_en_o)
    );

endmodule

// File: rtl/digit_gate_mod_chk.sv
module digit_gate_mod_chk #(
    parameter int DIGITS = 8,
    parameter int PERIOD = 28672
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        ctrl_i,
    input logic [DIGITS-1:0] flash_mask_i,
    input logic [DIGITS-1:0] digit_en_o,
    input logic              slow_phase_o
);
    localparam int HALF = PERIOD / 2;

    logic        prev_ph;
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ph <= 1'b1;
            run_q   <= '0;
        end else begin
            prev_ph <= slow_phase_o;
            run_q   <= (slow_phase_o != prev_ph) ? 32'd1 : run_q + 32'd1;
        end
    end

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i[2:0] == 3'd7) |-> (digit_en_o == '0)); // R3

    AST_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i == 5'd0) |-> (digit_en_o == '1)); // R4

    AST_BLINK_HIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i[4] && !slow_phase_o) |-> (digit_en_o == '0)); // R8

    AST_FLASH_MASKED_HIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i[3] && !slow_phase_o) |-> ((digit_en_o & flash_mask_i) == '0)); // R6

    AST_MASK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i[4:3] == 2'b00) |->
        ($countones(digit_en_o) == 0 || $countones(digit_en_o) == DIGITS)); // R7

    AST_PHASE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_phase_o != prev_ph) |-> (run_q == 32'(HALF))); // R5

    AST_PHASE_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 32'(HALF)); // R5

endmodule

bind digit_gate_mod digit_gate_mod_chk #(.DIGITS(DIGITS), .PERIOD(PERIOD)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_i       (ctrl_i),
    .flash_mask_i (flash_mask_i),
    .digit_en_o   (digit_en_o),
    .slow_phase_o (slow_phase_o)
);

// File: tb/digit_gate_mod_bench.sv
module digit_gate_mod_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ctrl = 5'd0;
    logic [7:0] mask = 8'd0;
    logic [7:0] en;
    logic       ph;

    int checks = 0;
    int errors = 0;
    int cyc;
    bit finished = 0;

    always #10 clk = ~clk;

    digit_gate_mod u_digit_gate_mod (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_i       (ctrl),
        .flash_mask_i (mask),
        .digit_en_o   (en),
        .slow_phase_o (ph)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic int ref_lit(input logic [2:0] c);
        case (c)
            3'd0: return 15;
            3'd1: return 12;
            3'd2: return 8;
            3'd3: return 6;
            3'd4: return 4;
            3'd5: return 3;
            3'd6: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic ref_phase(input int k);
        return (k % 28672) < 14336;
    endfunction

    function automatic logic [7:0] ref_en(input int k, input logic [4:0] c, input logic [7:0] m);
        logic [7:0] r;
        logic on;
        on = (k % 15) < ref_lit(c[2:0]);
        for (int i = 0; i < 8; i++)
            r[i] = on & (ref_phase(k) | ~(c[4] | (c[3] & m[i])));
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ctrl = 5'd0;
        mask = 8'hA5;
        @(negedge clk);
        @(negedge clk);
        check(en == 8'hFF, "R1 enables in reset", en, 8'hFF);
        check(ph == 1'b1, "R1 phase in reset", ph, 1);
        rst_n = 1'b1;
        #1;
        check(en == 8'hFF, "R1 enables after release", en, 8'hFF);
        check(ph == 1'b1, "R1 phase after release", ph, 1);
    endtask

    task automatic step_check();
        logic [7:0] e;
        string tag;
        @(negedge clk);
        e = ref_en(cyc, ctrl, mask);
        check(ph == ref_phase(cyc), "R5 slow phase", ph, ref_phase(cyc));
        if (ctrl[2:0] == 3'd7)                   tag = "R3 blank";
        else if (ctrl[4])                        tag = "R8 blink";
        else if (ctrl[3])                        tag = "R6 flash";
        else if (mask != 0)                      tag = "R7 mask ignored";
        else if (ctrl[2:0] == 3'd0)              tag = "R4 full on";
        else                                     tag = "R9 slot position";
        check(en == e, tag, en, e);
    endtask

    initial begin
        #(20 * 190000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset();

        // R2: lit slots per aligned frame for every code
        for (int c = 0; c < 8; c++) begin
            int lit;
            ctrl = 5'(c);
            mask = 8'hFF;
            while (cyc % 15 != 14) @(negedge clk);
            lit = 0;
            for (int s = 0; s < 15; s++) begin
                @(negedge clk);
                if (en[3]) lit++;
            end
            check(lit == ref_lit(3'(c)), "R2 lit slots per frame", lit, ref_lit(3'(c)));
        end

        // Directed: blink overrides flash with mask all zero
        ctrl = 5'b11000;
        mask = 8'h00;
        for (int i = 0; i < 40; i++) step_check();

        // Random mix over more than two slow periods
        for (int i = 0; i < 62000; i++) begin
            if (i % 7 == 0) begin
                logic [31:0] r;
                r = $urandom;
                ctrl[2:0] = (r[3:0] < 4) ? 3'd0 : r[6:4];
                ctrl[3]   = r[8];
                ctrl[4]   = (r[11:9] == 3'd0);
                mask      = r[23:16];
            end
            step_check();
        end

        // R1: reset mid-run restarts both timebases
        do_reset();
        ctrl = 5'b01001;
        mask = 8'h3C;
        for (int i = 0; i < 30; i++) step_check();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule